// File: doc/BRIEF.md
# RV32 Arithmetic-Logic Unit with Low-Half Multiply

This block is the execute-stage arithmetic unit of a small RV32 integer core, together with the decoder slice that recognises register-register arithmetic instructions. The arithmetic side takes two 32-bit operands and a 4-bit operation code. It returns the 32-bit result of the usual integer operations. It also supports one extra multiply, which forms the product of the low 16 bits of each operand. Because both factors are at most 16 bits wide, the unsigned product always fits in 32 bits. No overflow or upper-half handling is needed.

The decode side looks at a 32-bit instruction word. When the word is a register-register arithmetic instruction, including the multiply, the decoder produces the operation code that drives the arithmetic side. It also produces the register indices and the control row used by the surrounding pipeline: next-PC source, B-operand source, memory and CSR enables, and writeback enable and source. Both halves are purely combinational. Results settle in the same cycle that the inputs are applied.

Top module: `alu_mul_unit`

## Requirements
- R1: With operation code 12 (MUL), the result is the unsigned product of operand A bits [15:0] and operand B bits [15:0], zero-extended to 32 bits; bits [31:16] of either operand have no effect.
- R2: Code 0 (ADD) returns A+B and code 1 (SUB) returns A-B, both modulo 2^32.
- R3: Code 2 returns A AND B, code 3 returns A OR B, code 4 returns A XOR B.
- R4: Code 6 (SLL), 8 (SRL) and 9 (SRA) shift A by B[4:0]; SRA fills with A[31], the others with zero, and B[31:5] is ignored.
- R5: Code 5 (SLT) returns 1 when A is less than B as signed numbers, code 7 (SLTU) when less as unsigned numbers, else 0.
- R6: Code 10 returns A unchanged, code 11 returns B unchanged, and the unused codes 13, 14 and 15 return zero.
- R7: A word with opcode bits [6:0]=0110011, funct3 bits [14:12]=000 and funct7 bits [31:25]=0000001 decodes as MUL: is_mul_o=1, legal_o=1, alu_op_o=12.
- R8: The word 0x02F707B3 decodes as MUL with rd_o=15 (bits [11:7]), rs1_o=14 (bits [19:15]) and rs2_o=15 (bits [24:20]).
- R9: Every legal register-register word, MUL included, yields pc_sel_o=00 (PC+4), b_sel_o=1 (B from rs2, not an immediate), load_o=0, store_o=0, csr_o=0, wb_en_o=1 and wb_sel_o=00 (ALU result).
- R10: With opcode 0110011 and funct3 000, funct7 0000000 decodes as ADD (alu_op_o=0) and funct7 0100000 as SUB (alu_op_o=1); neither sets is_mul_o.
- R11: Any other opcode, or a funct7/funct3 pairing outside R7 and the RV32I register-register set, gives legal_o=0, is_mul_o=0, wb_en_o=0 and all enables zero.
- R12: Both the result and the decoded controls follow their inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| op_i | input | 4 | Operation code (see R1–R6 for values) |
| result_o | output | 32 | Operation result |
| instr_i | input | 32 | Instruction word to decode |
| legal_o | output | 1 | Word is a supported register-register instruction |
| is_mul_o | output | 1 | Word is the low-half multiply |
| alu_op_o | output | 4 | Operation code for the arithmetic side |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| pc_sel_o | output | 2 | Next-PC source, 00 = PC+4 |
| b_sel_o | output | 1 | 1 = B from rs2, 0 = immediate |
| load_o | output | 1 | Memory read enable |
| store_o | output | 1 | Memory write enable |
| csr_o | output | 1 | CSR access enable |
| wb_en_o | output | 1 | Register writeback enable |
| wb_sel_o | output | 2 | Writeback source, 00 = ALU result |

## Verification
Every result of this block is due zero cycles after its stimulus: the arithmetic output and all decode fields are combinational functions of the present inputs. The bench changes inputs just after a rising clock edge and samples at the following falling edge, half a period later, so nothing depends on process ordering at an edge. For R12 the bench changes operands twice within one clock phase and samples 1 ns after each change, with no edge in between, to show that no register sits on the path.

// File: rtl/alu_mul_pkg.sv
package alu_mul_pkg;

    localparam int XLEN    = 32;
    localparam int OPW     = 4;
    localparam int REGW    = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_SLT   = 4'd5,
        OP_SLL   = 4'd6,
        OP_SLTU  = 4'd7,
        OP_SRL   = 4'd8,
        OP_SRA   = 4'd9,
        OP_PASSA = 4'd10,
        OP_PASSB = 4'd11,
        OP_MUL   = 4'd12
    } alu_op_e;

    localparam logic [6:0] OPC_REGREG = 7'b0110011;
    localparam logic [6:0] F7_BASE    = 7'b0000000;
    localparam logic [6:0] F7_ALT     = 7'b0100000;
    localparam logic [6:0] F7_MULDIV  = 7'b0000001;

    localparam logic [1:0] NPC_SEQ    = 2'b00;
    localparam logic [1:0] WBSRC_ALU  = 2'b00;

    typedef struct packed {
        logic            legal;
        logic            is_mul;
        logic [OPW-1:0]  alu_op;
        logic [1:0]      pc_sel;
        logic            b_sel;
        logic            load;
        logic            store;
        logic            csr;
        logic            wb_en;
        logic [1:0]      wb_sel;
    } ctrl_row_t;

endpackage

// File: rtl/lo_half_mul.sv
module lo_half_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prod_o
);
    localparam int HALF = WIDTH / 2;

    logic [HALF-1:0] a_lo;
    logic [HALF-1:0] b_lo;

    always_comb begin
        a_lo   = a_i[HALF-1:0];
        b_lo   = b_i[HALF-1:0];
        prod_o = WIDTH'(a_lo) * WIDTH'(b_lo);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [OPW-1:0]   op_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH-1:0] mul_res;
    logic [SHW-1:0]   shamt;
    logic [WIDTH-1:0] res_d;

    lo_half_mul #(.WIDTH(WIDTH)) i_mul (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (mul_res)
    );

    always_comb begin
        shamt = opb_i[SHW-1:0];
        res_d = '0;
        case (op_i)
            OP_ADD:   res_d = opa_i + opb_i;
            OP_SUB:   res_d = opa_i - opb_i;
            OP_AND:   res_d = opa_i & opb_i;
            OP_OR:    res_d = opa_i | opb_i;
            OP_XOR:   res_d = opa_i ^ opb_i;
            OP_SLT:   res_d = WIDTH'($signed(opa_i) < $signed(opb_i));
            OP_SLTU:  res_d = WIDTH'(opa_i < opb_i);
            OP_SLL:   res_d = opa_i << shamt;
            OP_SRL:   res_d = opa_i >> shamt;
            OP_SRA:   res_d = WIDTH'($signed(opa_i) >>> shamt);
            OP_PASSA: res_d = opa_i;
            OP_PASSB: res_d = opb_i;
            OP_MUL:   res_d = mul_res;
            default:  res_d = '0;
        endcase
        result_o = res_d;
    end
endmodule

// File: rtl/regreg_decode.sv
module regreg_decode
    import alu_mul_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output ctrl_row_t       ctrl_o,
    output logic [REGW-1:0] rd_o,
    output logic [REGW-1:0] rs1_o,
    output logic [REGW-1:0] rs2_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    ctrl_row_t  ctrl_d;
    logic       hit;
    logic [OPW-1:0] op_sel;

    always_comb begin
        opc    = instr_i[6:0];
        f3     = instr_i[14:12];
        f7     = instr_i[31:25];
        hit    = 1'b0;
        op_sel = OP_ADD;

        if (opc == OPC_REGREG) begin
            if (f7 == F7_MULDIV) begin
                if (f3 == 3'b000) begin
                    hit    = 1'b1;
                    op_sel = OP_MUL;
                end
            end else if (f7 == F7_BASE) begin
                hit = 1'b1;
                case (f3)
                    3'b000: op_sel = OP_ADD;
                    3'b001: op_sel = OP_SLL;
                    3'b010: op_sel = OP_SLT;
                    3'b011: op_sel = OP_SLTU;
                    3'b100: op_sel = OP_XOR;
                    3'b101: op_sel = OP_SRL;
                    3'b110: op_sel = OP_OR;
                    default: op_sel = OP_AND;
                endcase
            end else if (f7 == F7_ALT) begin
                if (f3 == 3'b000) begin
                    hit    = 1'b1;
                    op_sel = OP_SUB;
                end else if (f3 == 3'b101) begin
                    hit    = 1'b1;
                    op_sel = OP_SRA;
                end
            end
        end

        ctrl_d = '0;
        if (hit) begin
            ctrl_d.legal  = 1'b1;
            ctrl_d.is_mul = (op_sel == OP_MUL);
            ctrl_d.alu_op = op_sel;
            ctrl_d.pc_sel = NPC_SEQ;
            ctrl_d.b_sel  = 1'b1;
            ctrl_d.wb_en  = 1'b1;
            ctrl_d.wb_sel = WBSRC_ALU;
        end

        ctrl_o = ctrl_d;
        rd_o   = instr_i[11:7];
        rs1_o  = instr_i[19:15];
        rs2_o  = instr_i[24:20];
    end
endmodule

// File: rtl/alu_mul_unit.sv
module alu_mul_unit
    import alu_mul_pkg::*;
(
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    input  logic [3:0]  op_i,
    output logic [31:0] result_o,
    input  logic [31:0] instr_i,
    output logic        legal_o,
    output logic        is_mul_o,
    output logic [3:0]  alu_op_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [1:0]  pc_sel_o,
    output logic        b_sel_o,
    output logic        load_o,
    output logic        store_o,
    output logic        csr_o,
    output logic        wb_en_o,
    output logic [1:0]  wb_sel_o
);
    ctrl_row_t ctrl_q;

    alu_core #(.WIDTH(XLEN)) i_core (
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .op_i     (op_i),
        .result_o (result_o)
    );

    regreg_decode i_dec (
        .instr_i (instr_i),
        .ctrl_o  (ctrl_q),
        .rd_o    (rd_o),
        .rs1_o   (rs1_o),
        .rs2_o   (rs2_o)
    );

    always_comb begin
        legal_o  = ctrl_q.legal;
        is_mul_o = ctrl_q.is_mul;
        alu_op_o = ctrl_q.alu_op;
        pc_sel_o = ctrl_q.pc_sel;
        b_sel_o  = ctrl_q.b_sel;
        load_o   = ctrl_q.load;
        store_o  = ctrl_q.store;
        csr_o    = ctrl_q.csr;
        wb_en_o  = ctrl_q.wb_en;
        wb_sel_o = ctrl_q.wb_sel;
    end
endmodule

// File: rtl/alu_mul_unit_chk.sv
module alu_mul_unit_chk (
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic [3:0]  op_i,
    input logic [31:0] result_o,
    input logic [31:0] instr_i,
    input logic        legal_o,
    input logic        is_mul_o,
    input logic [3:0]  alu_op_o,
    input logic [1:0]  pc_sel_o,
    input logic        b_sel_o,
    input logic        load_o,
    input logic        store_o,
    input logic        csr_o,
    input logic        wb_en_o,
    input logic [1:0]  wb_sel_o
);
    always_comb begin
        if (op_i == 4'd12 && opa_i[15:0] == 16'h0)
            p_mul_zero_factor_r1: assert (result_o == 32'h0);
        if (op_i == 4'd0)
            p_add_inverse_r2: assert (result_o - opb_i == opa_i);
        if (op_i == 4'd5 || op_i == 4'd7)
            p_compare_bool_r5: assert (result_o[31:1] == 31'h0);
        if (is_mul_o)
            p_mul_code_r7: assert (legal_o && alu_op_o == 4'd12);
        if (legal_o)
            p_row_shape_r9: assert (wb_en_o && b_sel_o && !load_o && !store_o
                                    && !csr_o && pc_sel_o == 2'b00 && wb_sel_o == 2'b00);
        if (instr_i[31:25] != 7'b0000001)
            p_no_mul_other_f7_r10: assert (!is_mul_o);
        if (!legal_o)
            p_illegal_quiet_r11: assert (!wb_en_o && !is_mul_o && !load_o && !store_o && !csr_o);
    end
endmodule

bind alu_mul_unit alu_mul_unit_chk i_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .op_i     (op_i),
    .result_o (result_o),
    .instr_i  (instr_i),
    .legal_o  (legal_o),
    .is_mul_o (is_mul_o),
    .alu_op_o (alu_op_o),
    .pc_sel_o (pc_sel_o),
    .b_sel_o  (b_sel_o),
    .load_o   (load_o),
    .store_o  (store_o),
    .csr_o    (csr_o),
    .wb_en_o  (wb_en_o),
    .wb_sel_o (wb_sel_o)
);

// File: tb/test_alu_mul_unit.sv
`timescale 1ns/1ps
module test_alu_mul_unit;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] opa, opb, res, instr;
    logic [3:0]  op, aop;
    logic        legal, ismul, bsel, ld, st, csr, wben;
    logic [4:0]  rd, rs1, rs2;
    logic [1:0]  pcsel, wbsel;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    alu_mul_unit i_alu_mul_unit (
        .opa_i(opa), .opb_i(opb), .op_i(op), .result_o(res),
        .instr_i(instr), .legal_o(legal), .is_mul_o(ismul), .alu_op_o(aop),
        .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .pc_sel_o(pcsel), .b_sel_o(bsel),
        .load_o(ld), .store_o(st), .csr_o(csr), .wb_en_o(wben), .wb_sel_o(wbsel)
    );

    // op(4) | A(32) | B(32) | expected(32)
    localparam int NV = 18;
    localparam logic [99:0] VEC [NV] = '{
        {4'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000}, // R2
        {4'd0,  32'hFFFFFFFF, 32'h00000002, 32'h00000001}, // R2
        {4'd1,  32'h00000005, 32'h00000007, 32'hFFFFFFFE}, // R2
        {4'd2,  32'hF0F0FF00, 32'h0FF0F0F0, 32'h00F0F000}, // R3
        {4'd3,  32'hF0F0FF00, 32'h0FF0F0F0, 32'hFFF0FFF0}, // R3
        {4'd4,  32'hF0F0FF00, 32'h0FF0F0F0, 32'hFF000FF0}, // R3
        {4'd6,  32'h00000001, 32'h00000024, 32'h00000010}, // R4
        {4'd8,  32'h80000000, 32'h0000001F, 32'h00000001}, // R4
        {4'd9,  32'h80000000, 32'h00000004, 32'hF8000000}, // R4
        {4'd5,  32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R5
        {4'd7,  32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R5
        {4'd10, 32'h12345678, 32'h00000009, 32'h12345678}, // R6
        {4'd11, 32'h12345678, 32'h00000009, 32'h00000009}, // R6
        {4'd12, 32'hABCD0003, 32'h12340005, 32'h0000000F}, // R1
        {4'd12, 32'h0000FFFF, 32'h0000FFFF, 32'hFFFE0001}, // R1
        {4'd12, 32'hFFFF8000, 32'h00000002, 32'h00010000}, // R1
        {4'd13, 32'h12345678, 32'h00000009, 32'h00000000}, // R6
        {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}  // R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic apply_at_edge();
        @(posedge clk);
        #0.5;
    endtask

    task automatic chk_row(input string req);
        chk(req, {25'h0, pcsel, bsel, ld, st, csr, wben, wbsel},
                 {25'h0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00});
    endtask

    task automatic chk_dead(input string req);
        chk(req, {24'h0, legal, ismul, bsel, ld, st, csr, wben, 1'b0},
                 32'h0);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; op = '0; instr = '0;
        @(negedge clk);
        // initial state: all-zero inputs
        chk("R2 idle result", res, 32'h0);
        chk("R11 idle decode legal", {31'h0, legal}, 32'h0);
        chk("R11 idle wb_en", {31'h0, wben}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply_at_edge();
            op  = VEC[i][99:96];
            opa = VEC[i][95:64];
            opb = VEC[i][63:32];
            @(negedge clk);
            chk($sformatf("R1-6 vector %0d op %0d", i, VEC[i][99:96]), res, VEC[i][31:0]);
        end

        // R12: two changes within one phase, no clock edge between
        apply_at_edge();
        op = 4'd12; opa = 32'h00000003; opb = 32'h00000004;
        #1 chk("R12 first change", res, 32'h0000000C);
        opa = 32'h00000100;
        #1 chk("R12 second change", res, 32'h00000400);

        // R1: upper halves ignored
        apply_at_edge();
        opa = 32'h55550007; opb = 32'hAAAA0006;
        @(negedge clk);
        chk("R1 upper halves ignored", res, 32'h0000002A);

        // R7 / R8 / R9: MUL word
        apply_at_edge();
        instr = 32'h02F707B3;
        @(negedge clk);
        chk("R7 is_mul", {31'h0, ismul}, 32'h1);
        chk("R7 legal", {31'h0, legal}, 32'h1);
        chk("R7 alu op", {28'h0, aop}, 32'd12);
        chk("R8 rd", {27'h0, rd}, 32'd15);
        chk("R8 rs1", {27'h0, rs1}, 32'd14);
        chk("R8 rs2", {27'h0, rs2}, 32'd15);
        chk_row("R9 mul row");

        // R10: ADD and SUB
        apply_at_edge();
        instr = 32'h003100B3;
        @(negedge clk);
        chk("R10 add not mul", {31'h0, ismul}, 32'h0);
        chk("R10 add op", {28'h0, aop}, 32'd0);
        chk_row("R9 add row");
        apply_at_edge();
        instr = 32'h403100B3;
        @(negedge clk);
        chk("R10 sub not mul", {31'h0, ismul}, 32'h0);
        chk("R10 sub op", {28'h0, aop}, 32'd1);

        // R9: SRA word
        apply_at_edge();
        instr = 32'h403150B3;
        @(negedge clk);
        chk("R9 sra op", {28'h0, aop}, 32'd9);
        chk_row("R9 sra row");

        // R11: out-of-scope multiply variant and an immediate-form word
        apply_at_edge();
        instr = 32'h023110B3;
        @(negedge clk);
        chk_dead("R11 funct3 001 with funct7 0000001");
        apply_at_edge();
        instr = 32'h00310093;
        @(negedge clk);
        chk_dead("R11 non-register opcode");
        apply_at_edge();
        instr = 32'h203100B3;
        @(negedge clk);
        chk_dead("R11 unknown funct7");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule